// File: doc/BRIEF.md
# Supply Monitor Reset/Interrupt Controller

This block holds the digital control logic behind a low-supply detector. An analog comparator, outside the block, reports on one bit whether the supply sits above the selected threshold. The block sends the threshold choice back to the analog side as a 4-bit code. The comparator bit first passes through a synchronizer and then a programmable noise filter. The block keeps a live monitor flag and a sticky crossing flag. From these it produces a reset request, a maskable interrupt, a non-maskable interrupt and an event pulse for an event-routing fabric, according to the settings that software writes.

Software writes three registers through a simple write port. The control word sits at address 0, the threshold code at address 1 and the reset-release delay at address 2. Control word bits: [0] monitor enable, [1] mode (1 = reset, 0 = interrupt), [3:2] crossing select, [4] interrupt type (1 = non-maskable), [5] interrupt enable, [6] release policy, [8:7] filter length, [9] write-one-to-clear for the crossing flag. No register can be read back. The state is visible on the output ports.

Top module: `supply_monitor`

## Requirements
- R1: Writing a code from 0 to 9 to address 1 (bits [3:0]) updates `levelSel`. Writing a code from 10 to 15 is ignored and `levelSel` keeps its value. `levelSel` is 0 after reset.
- R2: `monFlag` follows `supplyAbove` after a two-flop synchronizer and a filter. The filter needs 1, 2, 4 or 8 consecutive equal samples, chosen by control bits [8:7] = 0, 1, 2, 3. `monFlag` is 0 after reset.
- R3: A change on `supplyAbove` that lasts fewer cycles than the filter length does not change `monFlag`.
- R4: `detFlag` sets on a qualified crossing. It stays set until a control write with bit 9 = 1 clears it.
- R5: Crossing select (control bits [3:2]): 0 qualifies rising crossings (supply goes above the threshold), 1 qualifies falling crossings, and 2 or 3 qualifies both.
- R6: `evtPulse` is high for exactly one cycle per qualified crossing, one cycle after `monFlag` changes. This holds whatever the interrupt enable is.
- R7: Reset mode with release policy 0 (control bit 6 = 0): `rstReq` rises one cycle after `monFlag` falls and stays high while the supply is below the threshold. It falls D+2 cycles after `monFlag` rises, where D is the value at address 2. A drop during the countdown keeps reset high and restarts the delay.
- R8: Reset mode with release policy 1: `rstReq` rises one cycle after `monFlag` falls and falls D+1 cycles later, even if the supply is still low. A new fall during the countdown reloads the delay.
- R9: Interrupt mode with the maskable type (bit 4 = 0, bit 5 = 1): `irqReq` is a level that stays high while `detFlag` is set, and it drops when `detFlag` is cleared.
- R10: Interrupt mode with the non-maskable type (bit 4 = 1, bit 5 = 1): `nmiReq` pulses once per qualified crossing and `irqReq` stays low.
- R11: While monitoring is enabled, a legal threshold write or a write that changes the mode bit blocks crossing detection for the next 2 cycles. A crossing that the filter accepts in that window sets neither `detFlag` nor `evtPulse`.
- R12: With the monitor disabled (bit 0 = 0), crossings produce no `evtPulse`, no `detFlag` and no `rstReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyAbove | input | 1 | Raw comparator bit, 1 = supply above threshold |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 2 | Register address |
| cfgWdata | input | 16 | Register write data |
| levelSel | output | 4 | Threshold code sent to the analog side |
| monFlag | output | 1 | Filtered live comparator state |
| detFlag | output | 1 | Sticky qualified-crossing flag |
| rstReq | output | 1 | Reset request |
| irqReq | output | 1 | Maskable interrupt level |
| nmiReq | output | 1 | Non-maskable interrupt pulse |
| evtPulse | output | 1 | One-cycle event on each qualified crossing |

## Verification
On every cycle the assertions check the following:
- the threshold code stays within its ten legal values;
- each event, non-maskable pulse and rise of the crossing flag lines up with the others;
- no event comes out of a masked cycle;
- the countdown loads the programmed delay;
- under policy 0, reset only drops while the supply is above the threshold.

Only the bench scenarios can show the exact release counts of both policies, the restart after a drop during the countdown, and filter rejection of short glitches. The same holds for the event counts under each crossing selection and for the masking window around a threshold change.

// File: rtl/smon_pkg.sv
package smon_pkg;
  localparam int CTRL_ADDR  = 0;
  localparam int LEVEL_ADDR = 1;
  localparam int DELAY_ADDR = 2;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_BOTH = 2'd2,
    EDGE_ANY  = 2'd3
  } edgeSelT;

  typedef enum logic [1:0] {
    RST_IDLE  = 2'd0,
    RST_HOLD  = 2'd1,
    RST_COUNT = 2'd2
  } rstStateT;

  typedef struct packed {
    logic       enable;
    logic       resetMode;
    edgeSelT    edgeSel;
    logic       nmiSel;
    logic       intEnable;
    logic       relPolicy;
    logic [1:0] filtSel;
  } ctrlT;

  // strobes from control to the datapath countdown
  typedef struct packed {
    logic load;
    logic dec;
  } cntStrobeT;
endpackage

// File: rtl/smon_datapath.sv
module smon_datapath
  import smon_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int FILT_LOG_MAX = 3,
  parameter int DELAY_W      = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               supplyAbove,
  input  logic [1:0]         filtSel,
  input  logic [DELAY_W-1:0] delayVal,
  input  cntStrobeT          cntStb,
  output logic               filtLevel,
  output logic               riseStb,
  output logic               fallStb,
  output logic               cntZero
);
  localparam int RUN_W = FILT_LOG_MAX + 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   sampled;
  logic [RUN_W-1:0]       runCnt;
  logic [RUN_W-1:0]       runNeed;
  logic [DELAY_W-1:0]     delayCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], supplyAbove};
  end
  assign sampled = syncQ[SYNC_STAGES-1];

  assign runNeed = RUN_W'(1) << filtSel;

  // noise filter: flips only after runNeed consecutive differing samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtLevel <= 1'b0;
      runCnt    <= '0;
      riseStb   <= 1'b0;
      fallStb   <= 1'b0;
    end else begin
      riseStb <= 1'b0;
      fallStb <= 1'b0;
      if (sampled == filtLevel) begin
        runCnt <= '0;
      end else if (runCnt + RUN_W'(1) >= runNeed) begin
        filtLevel <= sampled;
        runCnt    <= '0;
        riseStb   <= sampled;
        fallStb   <= !sampled;
      end else begin
        runCnt <= runCnt + RUN_W'(1);
      end
    end
  end

  // reset-release countdown
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           delayCnt <= '0;
    else if (cntStb.load)                delayCnt <= delayVal;
    else if (cntStb.dec && !cntZero)     delayCnt <= delayCnt - DELAY_W'(1);
  end
  assign cntZero = (delayCnt == '0);

  // R7
  reload_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntStb.load |=> delayCnt == $past(delayVal))
    else $error("countdown did not load delay");
endmodule

// File: rtl/smon_control.sv
module smon_control
  import smon_pkg::*;
#(
  parameter int LEVEL_W     = 4,
  parameter int NUM_LEVELS  = 10,
  parameter int DELAY_W     = 16,
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 2,
  parameter int MASK_CYCLES = 2,
  parameter int DELAY_INIT  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [DATA_W-1:0]  cfgWdata,
  input  logic               filtLevel,
  input  logic               riseStb,
  input  logic               fallStb,
  input  logic               cntZero,
  output ctrlT               ctrl,
  output logic [DELAY_W-1:0] delayVal,
  output cntStrobeT          cntStb,
  output logic [LEVEL_W-1:0] levelSel,
  output logic               detFlag,
  output logic               rstReq,
  output logic               irqReq,
  output logic               nmiReq,
  output logic               evtPulse
);
  localparam int MASK_W  = $clog2(MASK_CYCLES + 1);
  localparam int CLR_BIT = 9;

  ctrlT              newCtrl;
  logic              wrCtrl, wrLevel, wrDelay, levelOk, detClr, maskTrig;
  logic [MASK_W-1:0] maskCnt;
  logic              masked, qualRise, qualFall, hit, active;
  rstStateT          state, stNext;

  always_comb begin
    newCtrl.enable    = cfgWdata[0];
    newCtrl.resetMode = cfgWdata[1];
    newCtrl.edgeSel   = edgeSelT'(cfgWdata[3:2]);
    newCtrl.nmiSel    = cfgWdata[4];
    newCtrl.intEnable = cfgWdata[5];
    newCtrl.relPolicy = cfgWdata[6];
    newCtrl.filtSel   = cfgWdata[8:7];
  end

  assign levelOk  = cfgWdata[LEVEL_W-1:0] < LEVEL_W'(NUM_LEVELS);
  assign wrCtrl   = cfgWe && (cfgAddr == ADDR_W'(CTRL_ADDR));
  assign wrLevel  = cfgWe && (cfgAddr == ADDR_W'(LEVEL_ADDR)) && levelOk;
  assign wrDelay  = cfgWe && (cfgAddr == ADDR_W'(DELAY_ADDR));
  assign detClr   = wrCtrl && cfgWdata[CLR_BIT];
  assign maskTrig = ctrl.enable &&
                    (wrLevel || (wrCtrl && (newCtrl.resetMode != ctrl.resetMode)));
  assign masked   = (maskCnt != '0);

  assign qualRise = riseStb && (ctrl.edgeSel != EDGE_FALL);
  assign qualFall = fallStb && (ctrl.edgeSel != EDGE_RISE);
  assign hit      = ctrl.enable && !masked && (qualRise || qualFall);
  assign active   = ctrl.enable && ctrl.resetMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrl     <= '0;
      levelSel <= '0;
      delayVal <= DELAY_W'(DELAY_INIT);
      maskCnt  <= '0;
      detFlag  <= 1'b0;
      evtPulse <= 1'b0;
      nmiReq   <= 1'b0;
    end else begin
      if (wrCtrl)  ctrl     <= newCtrl;
      if (wrLevel) levelSel <= cfgWdata[LEVEL_W-1:0];
      if (wrDelay) delayVal <= cfgWdata[DELAY_W-1:0];
      if (maskTrig)    maskCnt <= MASK_W'(MASK_CYCLES);
      else if (masked) maskCnt <= maskCnt - MASK_W'(1);
      if (hit)         detFlag <= 1'b1;
      else if (detClr) detFlag <= 1'b0;
      evtPulse <= hit;
      nmiReq   <= hit && !ctrl.resetMode && ctrl.intEnable && ctrl.nmiSel;
    end
  end

  // reset request sequencing
  always_comb begin
    stNext = state;
    cntStb = '0;
    if (!active) begin
      stNext = RST_IDLE;
    end else begin
      unique case (state)
        RST_IDLE: begin
          if (!ctrl.relPolicy) begin
            if (!filtLevel) stNext = RST_HOLD;
          end else if (fallStb) begin
            stNext      = RST_COUNT;
            cntStb.load = 1'b1;
          end
        end
        RST_HOLD: begin
          if (filtLevel || ctrl.relPolicy) begin
            stNext      = RST_COUNT;
            cntStb.load = 1'b1;
          end
        end
        RST_COUNT: begin
          if (!ctrl.relPolicy && !filtLevel) begin
            stNext = RST_HOLD;
          end else if (ctrl.relPolicy && fallStb) begin
            cntStb.load = 1'b1;
          end else if (cntZero) begin
            stNext = RST_IDLE;
          end else begin
            cntStb.dec = 1'b1;
          end
        end
        default: stNext = RST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= RST_IDLE;
    else       state <= stNext;
  end

  assign rstReq = (state != RST_IDLE);
  assign irqReq = detFlag && ctrl.enable && ctrl.intEnable &&
                  !ctrl.nmiSel && !ctrl.resetMode;

  // R1
  level_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    levelSel < LEVEL_W'(NUM_LEVELS))
    else $error("illegal threshold code");

  // R4
  det_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(detFlag) |-> evtPulse)
    else $error("crossing flag set without event");

  // R10
  nmi_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq |-> evtPulse)
    else $error("nmi pulse without event");

  // R11
  mask_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtPulse |-> !$past(masked))
    else $error("event during mask window");

  // R7
  release_above_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rstReq) && $past(ctrl.enable && ctrl.resetMode && !ctrl.relPolicy))
      |-> $past(filtLevel))
    else $error("reset released while supply low");
endmodule

// File: rtl/supply_monitor.sv
module supply_monitor
  import smon_pkg::*;
#(
  parameter int LEVEL_W     = 4,
  parameter int NUM_LEVELS  = 10,
  parameter int DELAY_W     = 16,
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int MASK_CYCLES = 2,
  parameter int DELAY_INIT  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               supplyAbove,
  input  logic               cfgWe,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [DATA_W-1:0]  cfgWdata,
  output logic [LEVEL_W-1:0] levelSel,
  output logic               monFlag,
  output logic               detFlag,
  output logic               rstReq,
  output logic               irqReq,
  output logic               nmiReq,
  output logic               evtPulse
);
  ctrlT               ctrl;
  cntStrobeT          cntStb;
  logic [DELAY_W-1:0] delayVal;
  logic               filtLevel, riseStb, fallStb, cntZero;

  smon_datapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .FILT_LOG_MAX(3),
    .DELAY_W     (DELAY_W)
  ) dpath (
    .clk        (clk),
    .rstN       (rstN),
    .supplyAbove(supplyAbove),
    .filtSel    (ctrl.filtSel),
    .delayVal   (delayVal),
    .cntStb     (cntStb),
    .filtLevel  (filtLevel),
    .riseStb    (riseStb),
    .fallStb    (fallStb),
    .cntZero    (cntZero)
  );

  smon_control #(
    .LEVEL_W    (LEVEL_W),
    .NUM_LEVELS (NUM_LEVELS),
    .DELAY_W    (DELAY_W),
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .MASK_CYCLES(MASK_CYCLES),
    .DELAY_INIT (DELAY_INIT)
  ) ctl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgAddr  (cfgAddr),
    .cfgWdata (cfgWdata),
    .filtLevel(filtLevel),
    .riseStb  (riseStb),
    .fallStb  (fallStb),
    .cntZero  (cntZero),
    .ctrl     (ctrl),
    .delayVal (delayVal),
    .cntStb   (cntStb),
    .levelSel (levelSel),
    .detFlag  (detFlag),
    .rstReq   (rstReq),
    .irqReq   (irqReq),
    .nmiReq   (nmiReq),
    .evtPulse (evtPulse)
  );

  assign monFlag = filtLevel;
endmodule

// File: tb/supply_monitor_test.sv
module supply_monitor_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        supplyAbove = 1'b1;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgAddr = '0;
  logic [15:0] cfgWdata = '0;
  logic [3:0]  levelSel;
  logic        monFlag, detFlag, rstReq, irqReq, nmiReq, evtPulse;

  int checkCount = 0;
  int failCount  = 0;
  int evtCount   = 0;
  int nmiCount   = 0;

  always #5 clk = ~clk;

  supply_monitor uut (
    .clk(clk), .rstN(rstN), .supplyAbove(supplyAbove),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .levelSel(levelSel), .monFlag(monFlag), .detFlag(detFlag),
    .rstReq(rstReq), .irqReq(irqReq), .nmiReq(nmiReq), .evtPulse(evtPulse)
  );

  always @(negedge clk) begin
    if (evtPulse) evtCount++;
    if (nmiReq)   nmiCount++;
  end

  function automatic logic [15:0] ctrlWord(bit en, bit rm, logic [1:0] es, bit nmi,
                                           bit ie, bit pol, logic [1:0] fs, bit clr);
    return {6'd0, clr, fs, pol, ie, nmi, es, rm, en};
  endfunction

  function automatic int qualifies(logic [1:0] es, bit rising);
    if (es[1]) return 1;
    return ((es == 2'd0) == rising) ? 1 : 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    tick();
    cfgWe = 1'b0;
  endtask

  task automatic waitMon(bit v, string tag);
    int n = 0;
    while (monFlag !== v && n < 100) begin
      tick();
      n++;
    end
    check(tag, monFlag, v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCount++;
    checkCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    int base, exp, nmiBase;
    bit cur;
    logic [1:0] es;
    void'($urandom(32'd4242));
    tick(3);
    // reset state
    check("R1 reset level", levelSel, 0);
    check("R2 reset mon", monFlag, 0);
    check("R12 reset outputs", {detFlag, rstReq, irqReq, nmiReq, evtPulse}, 0);
    rstN = 1'b1;
    tick(8);
    check("R2 mon follows high", monFlag, 1);

    // R1 threshold code
    wr(2'd1, 16'd7);  check("R1 legal 7", levelSel, 7);
    wr(2'd1, 16'd12); check("R1 illegal 12 ignored", levelSel, 7);
    wr(2'd1, 16'd9);  check("R1 legal 9", levelSel, 9);
    wr(2'd1, 16'd10); check("R1 illegal 10 ignored", levelSel, 9);

    // R3 filter with 4 samples, disabled monitor
    wr(2'd0, ctrlWord(0, 0, 2'd2, 0, 0, 0, 2'd2, 0));
    supplyAbove = 1'b0; tick(3); supplyAbove = 1'b1; tick(12);
    check("R3 3-cycle glitch rejected at N=4", monFlag, 1);
    supplyAbove = 1'b0; tick(4); supplyAbove = 1'b1; tick(1);
    tick(1);
    check("R2 4-cycle low accepted at N=4", monFlag, 0);
    tick(12);
    check("R2 recovers high", monFlag, 1);
    wr(2'd0, ctrlWord(0, 0, 2'd2, 0, 0, 0, 2'd3, 0));
    supplyAbove = 1'b0; tick(7); supplyAbove = 1'b1; tick(14);
    check("R3 7-cycle glitch rejected at N=8", monFlag, 1);
    // R12 disabled crossings: no event, no flag
    base = evtCount;
    supplyAbove = 1'b0; tick(20); supplyAbove = 1'b1; tick(20);
    check("R12 no event when disabled", evtCount - base, 0);
    check("R12 no flag when disabled", detFlag, 0);

    // R5/R6 random crossings with random edge select and filter length
    cur = 1'b1;
    for (int r = 0; r < 8; r++) begin
      es = 2'($urandom % 4);
      wr(2'd0, ctrlWord(1, 0, es, 0, 0, 0, 2'($urandom % 4), 1));
      check("R4 flag cleared", detFlag, 0);
      base = evtCount; exp = 0;
      for (int k = 0; k < 7; k++) begin
        cur = !cur;
        supplyAbove = cur;
        exp += qualifies(es, cur);
        tick(12 + int'($urandom % 20));
      end
      check("R5 event count for edge select", evtCount - base, exp);
      check("R4 flag reflects crossings", detFlag, (exp > 0) ? 1 : 0);
      check("R2 mon settles", monFlag, cur);
    end
    if (!cur) begin supplyAbove = 1'b1; tick(20); end

    // R6 pulse timing, interrupt disabled
    wr(2'd0, ctrlWord(1, 0, 2'd2, 0, 0, 0, 2'd0, 1));
    supplyAbove = 1'b0;
    waitMon(0, "R6 mon falls");
    check("R6 no event same cycle", evtPulse, 0);
    tick(); check("R6 event one cycle later", evtPulse, 1);
    tick(); check("R6 event lasts one cycle", evtPulse, 0);
    check("R9 no irq when disabled", irqReq, 0);

    // R11 masking window around a threshold write
    base = evtCount;
    wr(2'd0, ctrlWord(1, 0, 2'd2, 0, 0, 0, 2'd0, 1));
    supplyAbove = 1'b1; tick(); tick();
    wr(2'd1, 16'd3);
    tick(6);
    check("R11 mon still flips", monFlag, 1);
    check("R11 masked crossing no event", evtCount - base, 0);
    check("R11 masked crossing no flag", detFlag, 0);
    check("R1 legal 3", levelSel, 3);
    supplyAbove = 1'b0; tick(10);
    check("R11 detection resumes", evtCount - base, 1);

    // R9 maskable level interrupt
    supplyAbove = 1'b1; tick(10);
    wr(2'd0, ctrlWord(1, 0, 2'd2, 0, 1, 0, 2'd0, 1));
    supplyAbove = 1'b0; tick(8);
    check("R9 irq high with flag", irqReq, 1);
    tick(10);
    check("R9 irq stays high", irqReq, 1);
    wr(2'd0, ctrlWord(1, 0, 2'd2, 0, 1, 0, 2'd0, 1));
    check("R9 irq drops on clear", irqReq, 0);

    // R10 non-maskable pulse
    wr(2'd0, ctrlWord(1, 0, 2'd2, 1, 1, 0, 2'd0, 1));
    nmiBase = nmiCount;
    supplyAbove = 1'b1; tick(10);
    check("R10 one nmi pulse", nmiCount - nmiBase, 1);
    check("R10 no maskable irq", irqReq, 0);
    supplyAbove = 1'b0; tick(10);
    check("R10 second nmi pulse", nmiCount - nmiBase, 2);
    supplyAbove = 1'b1; tick(10);

    // R7 reset mode, release after delay with supply above
    wr(2'd2, 16'd20);
    wr(2'd0, ctrlWord(1, 1, 2'd2, 0, 0, 0, 2'd0, 1));
    tick(4);
    check("R7 no reset while above", rstReq, 0);
    supplyAbove = 1'b0;
    waitMon(0, "R7 mon falls");
    check("R7 reset not yet", rstReq, 0);
    tick(); check("R7 reset one cycle after fall", rstReq, 1);
    tick(30); check("R7 reset held while low", rstReq, 1);
    supplyAbove = 1'b1;
    waitMon(1, "R7 mon rises");
    tick(5);
    supplyAbove = 1'b0;
    waitMon(0, "R7 drop in countdown");
    check("R7 reset held on drop", rstReq, 1);
    supplyAbove = 1'b1;
    waitMon(1, "R7 mon rises again");
    tick(21); check("R7 reset at D+1", rstReq, 1);
    tick();   check("R7 released at D+2", rstReq, 0);

    // R8 policy 1: timed from the drop
    wr(2'd0, ctrlWord(1, 1, 2'd2, 0, 0, 1, 2'd0, 0));
    tick(3);
    supplyAbove = 1'b0;
    waitMon(0, "R8 mon falls");
    check("R8 reset not yet", rstReq, 0);
    tick(); check("R8 reset asserted", rstReq, 1);
    tick(20); check("R8 reset at D", rstReq, 1);
    tick();   check("R8 released while low", rstReq, 0);
    check("R8 supply still low", monFlag, 0);
    supplyAbove = 1'b1; tick(10);
    check("R8 no reset on rise", rstReq, 0);

    // R12 disabled reset mode
    wr(2'd0, ctrlWord(0, 1, 2'd2, 0, 0, 0, 2'd0, 1));
    base = evtCount;
    supplyAbove = 1'b0; tick(30);
    check("R12 no reset when disabled", rstReq, 0);
    check("R12 no event when disabled", evtCount - base, 0);
    supplyAbove = 1'b1; tick(10);

    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end
endmodule